// File: doc/BRIEF.md
# Periodic refresh request generator

This block paces memory refresh. A programmable down-counter runs in rate-generator fashion at one quarter of the system clock rate. Its output rests high and drops once in each period. A latch with its data input held at one is set on the rising edge of that output. The latch turns the short low pulse into a level request, and the request stays up until the refresh channel acknowledges it. While the acknowledge is active the latch is held clear. Any rising edge that arrives during that time is therefore lost, and no request is made for that period.

The whole block runs on one clock at twice the system rate (`clk_2x`), so that the half-cycle offset of the request is modelled exactly. The rising edges of `clk_2x` are numbered 1, 2, 3 … starting from the first edge after reset is released. An even edge number is a system clock edge. One counter clock lasts 8 edges. The count steps on edges ≡ 0 (mod 8). The counter output changes on edges ≡ 1 (mod 8), which fall halfway through a system clock. With reload 1, the output also drops again on edges ≡ 2 (mod 8). A reload value can be written at any time. It is held as pending and is loaded when the current count expires, so a write never cuts a count short. The control pins are plain levels and have no back-pressure. `wr_en` and `ack` are sampled on every `clk_2x` edge.

Top module: `refresh_req_gen`

## Requirements
- R1: After reset `req` is 0 and the count holds `RESET_RELOAD` (default 18). With the default, the first rise of `req` is on edge 145 (8·18+1).
- R2: With reload N, `req` rises every 8·N edges, which is 4·N system clocks. N=18 gives 72, N=19 gives 76 and N=2 gives 8 system clocks.
- R3: `req` rises only on edges ≡ 1 (mod 8), half a system clock out of phase with the system clock edges.
- R4: Once set, `req` stays at 1 on every edge where `ack` is sampled at 0.
- R5: `ack` sampled at 1 on an edge leaves `req` at 0 after that edge.
- R6: A rising edge of the counter output on an edge where `ack` is sampled at 1 sets no request. That period's request is lost, and `req` stays 0 until the next rising edge.
- R7: A reload written while a count runs takes effect at the next reload. The next rise comes 8·N_old edges after the previous one, and rises then follow every 8·N_new edges.
- R8: Reload 1 is accepted and gives one rise of `req` every 8 edges.
- R9: A write of value 0 is ignored, and the pending reload keeps its previous value.
- R10: When several writes land before a reload, the last nonzero value written is the one loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Clock at twice the system clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Reload write strobe |
| wr_val | input | CNT_W | Reload value to write (0 is ignored) |
| ack | input | 1 | Refresh channel acknowledge, level, clears the request |
| req | output | 1 | Refresh request level |

## Verification
The hardest case to reach is an acknowledge that is still active at the exact edge where the counter output rises, because in normal use the acknowledge ends long before the next period. The stimulus first shortens the period to 2 through a write and waits for that value to load at the next reload. It then holds `ack` over an edge window that contains one predicted rise. It expects that period to be missing and the following one to be present. The same run also steps through reload changes 18→2→1→19, including a zero write and two back-to-back writes. These check that each new value starts only after the count in progress has finished.

// File: rtl/rrg_pkg.sv
package rrg_pkg;
  localparam int PH_W = 3;
  typedef logic [PH_W-1:0] phase_t;
  // phase values as sampled at the edge where each action happens
  localparam phase_t PH_TICK  = 3'd7;  // count steps on the following edge
  localparam phase_t PH_LEAVE = 3'd0;  // output level updated
  localparam phase_t PH_TRIM  = 3'd1;  // extra low edge for reload 1
endpackage

// File: rtl/rrg_phase_gen.sv
module rrg_phase_gen
  import rrg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t ph_o
);
  phase_t ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_q + PH_W'(1);
  end

  assign ph_o = ph_q;

  AST_PH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ph_q == PH_W'($past(ph_q) + PH_W'(1))); // R3
endmodule

// File: rtl/rrg_reload_hold.sv
module rrg_reload_hold #(
  parameter int CNT_W        = 16,
  parameter int RESET_RELOAD = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_val_i,
  output logic [CNT_W-1:0] pend_o
);
  logic [CNT_W-1:0] pend_q;
  logic             take;

  assign take = wr_en_i && (wr_val_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_q <= CNT_W'(RESET_RELOAD);
    else if (take) pend_q <= wr_val_i;
  end

  assign pend_o = pend_q;

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_val_i == '0) |=> $stable(pend_q)); // R9
  AST_LAST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_val_i != '0) |=> pend_q == $past(wr_val_i)); // R10
  AST_PEND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q != '0); // R9
endmodule

// File: rtl/rrg_down_counter.sv
module rrg_down_counter
  import rrg_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int RESET_RELOAD = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           ph_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             lvl_o,
  output logic             rise_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             term_q;   // previous count step ended on 1
  logic             out_q;
  logic             out_d;
  logic             at_one;

  assign at_one = (cnt_q == ONE);

  always_comb begin
    out_d = out_q;
    if (ph_i == PH_LEAVE)
      out_d = !at_one || term_q;
    else if (ph_i == PH_TRIM && at_one && term_q)
      out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(RESET_RELOAD);
      term_q <= 1'b0;
      out_q  <= 1'b1;
    end else begin
      if (ph_i == PH_TICK) begin
        cnt_q  <= at_one ? reload_i : cnt_q - ONE;
        term_q <= at_one;
      end
      out_q <= out_d;
    end
  end

  assign lvl_o  = out_q;
  assign rise_o = out_d && !out_q;

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0); // R9
  AST_CNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_i != PH_TICK) |=> $stable(cnt_q)); // R7
  AST_OUT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(out_q)) |-> ($past(ph_i) == PH_LEAVE || $past(ph_i) == PH_TRIM)); // R3
endmodule

// File: rtl/rrg_req_latch.sv
module rrg_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic ack_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (ack_i)  req_q <= 1'b0;
    else if (rise_i) req_q <= 1'b1;
  end

  assign req_o = req_q;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !req_q); // R5
  AST_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i) |=> req_q); // R4
  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $rose(lvl_i)); // R3
  AST_RISE_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && ack_i) |=> !req_q); // R6
endmodule

// File: rtl/refresh_req_gen.sv
module refresh_req_gen
  import rrg_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int RESET_RELOAD = 18
) (
  input  logic             clk_2x,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             ack,
  output logic             req
);
  phase_t           ph;
  logic [CNT_W-1:0] pend;
  logic             lvl;
  logic             rise;

  rrg_phase_gen u_phase (
    .clk   (clk_2x),
    .rst_n (rst_n),
    .ph_o  (ph)
  );

  rrg_reload_hold #(.CNT_W(CNT_W), .RESET_RELOAD(RESET_RELOAD)) u_hold (
    .clk      (clk_2x),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_val_i (wr_val),
    .pend_o   (pend)
  );

  rrg_down_counter #(.CNT_W(CNT_W), .RESET_RELOAD(RESET_RELOAD)) u_cnt (
    .clk      (clk_2x),
    .rst_n    (rst_n),
    .ph_i     (ph),
    .reload_i (pend),
    .lvl_o    (lvl),
    .rise_o   (rise)
  );

  rrg_req_latch u_latch (
    .clk    (clk_2x),
    .rst_n  (rst_n),
    .lvl_i  (lvl),
    .rise_i (rise),
    .ack_i  (ack),
    .req_o  (req)
  );
endmodule

// File: tb/refresh_req_gen_tb_top.sv
module refresh_req_gen_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [CNT_W-1:0] wr_val = '0;
  logic             ack = 1'b0;
  logic             req;

  int checks = 0;
  int errors = 0;
  int edge_no = 0;
  bit done = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  refresh_req_gen #(.CNT_W(CNT_W), .RESET_RELOAD(18)) dut_i (
    .clk_2x (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_val (wr_val),
    .ack    (ack),
    .req    (req)
  );

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) if (rst_n) edge_no <= edge_no + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: edge %0d actual %0d expected %0d", tag, edge_no, act, exp);
    end
  endtask

  task automatic push_rise(input int e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic write_at(input int e, input int v);
    while (edge_no != e - 1) @(negedge clk);
    wr_en  = 1'b1;
    wr_val = CNT_W'(v);
    @(negedge clk);
    wr_en  = 1'b0;
  endtask

  // monitor and acknowledge responder
  localparam int HOLD_LO = 600;
  localparam int HOLD_HI = 620;
  bit prev_req = 1'b0;
  int ack_s = -100;
  int hi_at = -100;
  int lo_at = -100;

  always @(negedge clk) begin
    if (rst_n) begin
      if (req && !prev_req) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", edge_no, -1);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(edge_no == e, t, edge_no, e);
        end
        check(edge_no % 8 == 1, "R3", edge_no % 8, 1);
        hi_at = edge_no + 3;
        lo_at = edge_no + 5;
        ack_s = edge_no + 4;
      end
      if (edge_no == hi_at) check(req == 1'b1, "R4", int'(req), 1);
      if (edge_no == lo_at) check(req == 1'b0, "R5", int'(req), 0);
      if (edge_no == 612)   check(req == 1'b0, "R6", int'(req), 0);
      prev_req = req;
      ack = ((edge_no + 1 >= HOLD_LO) && (edge_no + 1 <= HOLD_HI)) ||
            ((edge_no + 1 >= ack_s) && (edge_no + 1 < ack_s + 2));
    end
  end

  initial begin
    push_rise(145, "R1");
    push_rise(289, "R2");
    push_rise(433, "R2");
    push_rise(577, "R7");   // reload 2 written at 440, loaded at 576
    push_rise(593, "R2");
    push_rise(625, "R6");   // 609 lost under held ack
    push_rise(641, "R7");   // reload 1 written at 630
    push_rise(649, "R8");
    push_rise(657, "R8");
    push_rise(665, "R8");
    push_rise(673, "R8");
    push_rise(681, "R7");   // reload 19 written at 675
    push_rise(833, "R9");   // zero write at 700 ignored
    push_rise(985, "R10");  // 5 then 4 written, 4 loaded at 984
    push_rise(1017, "R10");
    push_rise(1049, "R10");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(req == 1'b0, "R1", int'(req), 0);
    rst_n = 1'b1;

    write_at(440, 2);
    write_at(630, 1);
    write_at(675, 19);
    write_at(700, 0);
    write_at(840, 5);
    write_at(850, 4);
    while (edge_no < 1070) @(negedge clk);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: edge %0d actual 0 expected 1", edge_no);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule